// File: doc/BRIEF.md
# Virtual ROM Window Translator

This block sits between a soft CPU and its on-chip memory. It watches two request streams, instruction fetch and data access, for addresses that land in a read-only virtual window whose contents live in external serial flash. The window is divided into pages. Exactly one page at a time can be resident in an on-chip cache region. When a read targets a resident page, the block rewrites the address so that it points into the cache region and lets the request through. When a read targets a page that is not resident, the block withholds the memory request and raises an exception line. It also records the faulting address and which port caused the fault.

A software handler runs on the exception. It copies the page from flash into the cache region itself, then writes a control word to a fixed address. The write carries the new page number and a valid flag, and it clears the exception. Addresses outside the window, and writes into the window, go to memory unchanged. The block does no flash transfer and holds no cache storage. It only decides residency, signals the fault and translates addresses.

Top module: `vrom_window`

## Requirements
- R1: After reset the exception output is low, the recorded fault address is zero and no page is resident, so the first read into the window is a miss.
- R2: A request on either port whose address is below 0x10000 or at/above 0x18000 is forwarded in the same cycle with its address unchanged.
- R3: A read into the window that misses keeps that port's memory request low in the same cycle, and the exception output is high from the next clock edge.
- R4: On raising the exception the block records the faulting address, and sets the source flag to 1 for the fetch port and 0 for the data port. Address, flag and exception all hold unchanged, even across further misses, until an accepted control write.
- R5: A data write to address 0x00FFF0 is a control write and is never forwarded to memory. Bit 31 is the valid flag and bits [1:0] are the page number. An accepted control write clears the exception at the next edge.
- R6: A data read at a resident address is forwarded to 0x2000 + ((address − 0x10000) mod 0x2000). Resident means the page number, (address − 0x10000) / 0x2000, equals the stored page and valid is set.
- R7: Instruction fetches are translated and trapped by the same rule as data reads.
- R8: Data writes into the window are forwarded with their address unchanged and never raise the exception.
- R9: When both ports miss in the same cycle, the data port's address is the one recorded, with source flag 0.
- R10: A control write with bit 31 clear leaves no page resident, so a read to the previously stored page misses.
- R11: Once a different page is loaded, a read to the earlier page misses.
- R12: A control write with any of bits [30:2] set is ignored. It is still not forwarded, and the exception and the resident page stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | 24 | Fetch byte address (virtual) |
| if_mem_req | output | 1 | Fetch request forwarded to memory |
| if_mem_addr | output | 24 | Fetch address after translation |
| d_req | input | 1 | Data request |
| d_we | input | 1 | Data request is a write |
| d_addr | input | 24 | Data byte address (virtual) |
| d_wdata | input | 32 | Write data; decoded only for control writes |
| d_mem_req | output | 1 | Data request forwarded to memory |
| d_mem_addr | output | 24 | Data address after translation |
| trap | output | 1 | Exception to the CPU, held until acknowledged |
| fault_addr | output | 24 | Recorded faulting virtual address |
| fault_fetch | output | 1 | 1 if the recorded fault came from the fetch port |

## Verification
The hardest case to reach is two misses in the same cycle, one on each port, because the tie is settled only by the priority inside the fault recorder. The bench drives a fetch to one missing page and a data read to another missing page in the same cycle while no exception is pending. It then checks which address was captured. A second hard case is a miss that arrives while an earlier fault is still pending. The bench produces it by issuing a fault, then a second miss before any acknowledge, and confirms that the first record survives. The same holds after a control write with reserved bits set.

// File: rtl/vrom_pkg.sv
// Shared types for the virtual ROM window translator.
// Assumes: nothing beyond IEEE 1800-2017.
package vrom_pkg;
    // Which request port caused the recorded fault.
    typedef enum logic {
        SRC_DATA  = 1'b0,
        SRC_FETCH = 1'b1
    } fault_src_e;
endpackage

// File: rtl/vrom_xlate.sv
// Per-port address translator. Decides whether an address lies in the
// virtual window, whether its page is resident, and forms the cache address.
// Assumes: PAGE_BYTES is a power of two, WIN_BYTES a multiple of it, and
// the cache region holds one page aligned to PAGE_BYTES.
module vrom_xlate #(
    parameter int unsigned       ADDR_W     = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 24'h010000,
    parameter int unsigned       WIN_BYTES  = 32'h8000,
    parameter int unsigned       PAGE_BYTES = 32'h2000,
    parameter logic [ADDR_W-1:0] CACHE_BASE = 24'h002000,
    localparam int unsigned      NPAGES     = WIN_BYTES / PAGE_BYTES,
    localparam int unsigned      TAG_W      = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic              cur_valid,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              miss
);
    localparam int unsigned    PAGE_SH = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_BYTES);
    localparam logic [ADDR_W:0] CACHE_END = {1'b0, CACHE_BASE} + (ADDR_W+1)'(PAGE_BYTES);

    logic             in_win;
    logic [TAG_W-1:0] page_idx;
    logic             hit;

    // Window decode and page index of the incoming address.
    always_comb begin
        in_win   = ({1'b0, addr} >= {1'b0, WIN_BASE}) && ({1'b0, addr} < WIN_END);
        page_idx = TAG_W'((addr - WIN_BASE) >> PAGE_SH);
        hit      = cur_valid && (cur_tag == page_idx);
    end

    // Forwarding decision and physical address selection.
    always_comb begin
        miss     = req && !we && in_win && !hit;
        mem_req  = req && !miss;
        mem_addr = addr;
        if (in_win && !we) begin
            mem_addr = CACHE_BASE + ADDR_W'(addr[PAGE_SH-1:0]);
        end
    end

    // R3
    miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !cur_valid && in_win) |-> !mem_req);

    // R6
    xlate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && in_win && !we) |->
            (({1'b0, mem_addr} >= {1'b0, CACHE_BASE}) && ({1'b0, mem_addr} < CACHE_END)));

    // R8
    write_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |-> (mem_req && mem_addr == addr));
endmodule

// File: rtl/vrom_trap_ctl.sv
// Residency and fault state: stored page number, valid flag, pending
// exception, recorded fault address and source.
// Assumes: at most one control write per cycle; a data miss and a control
// write never coincide, since both use the data port.
module vrom_trap_ctl
    import vrom_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              d_miss,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              i_miss,
    input  logic [ADDR_W-1:0] i_addr,
    output logic [TAG_W-1:0]  tag,
    output logic              valid,
    output logic              trap,
    output logic [ADDR_W-1:0] fault_addr,
    output fault_src_e        fault_src
);
    logic [TAG_W-1:0]  tag_q;
    logic              valid_q;
    logic              trap_q;
    logic [ADDR_W-1:0] fault_addr_q;
    fault_src_e        fault_src_q;
    logic              accept;

    // A control write is accepted only with all reserved bits clear.
    always_comb begin
        accept = ctrl_wr && (wdata[DATA_W-2:TAG_W] == '0);
    end

    // State update: acknowledge first, then data miss, then fetch miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q        <= '0;
            valid_q      <= 1'b0;
            trap_q       <= 1'b0;
            fault_addr_q <= '0;
            fault_src_q  <= SRC_DATA;
        end else if (accept) begin
            tag_q   <= wdata[TAG_W-1:0];
            valid_q <= wdata[DATA_W-1];
            trap_q  <= 1'b0;
        end else if (!trap_q && d_miss) begin
            trap_q       <= 1'b1;
            fault_addr_q <= d_addr;
            fault_src_q  <= SRC_DATA;
        end else if (!trap_q && i_miss) begin
            trap_q       <= 1'b1;
            fault_addr_q <= i_addr;
            fault_src_q  <= SRC_FETCH;
        end
    end

    assign tag        = tag_q;
    assign valid      = valid_q;
    assign trap       = trap_q;
    assign fault_addr = fault_addr_q;
    assign fault_src  = fault_src_q;

    // R1
    reset_invalid_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_q && !trap_q));

    // R3
    miss_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_q && (d_miss || i_miss) && !accept) |=> trap_q);

    // R4
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_q && !accept) |=> (trap_q && $stable(fault_addr_q) && $stable(fault_src_q)));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !trap_q);

    // R9
    data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_q && d_miss && i_miss) |=> (fault_addr_q == $past(d_addr) && fault_src_q == SRC_DATA));

    // R12
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !accept && trap_q) |=> (trap_q && $stable(tag_q) && $stable(valid_q)));
endmodule

// File: rtl/vrom_window.sv
// Top of the virtual ROM window translator. Decodes the control write on the
// data port and runs one translator per request port against the shared
// residency state.
// Assumes: CTRL_ADDR lies outside the window; the CPU retries a blocked
// request after its exception handler returns.
module vrom_window
    import vrom_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 24,
    parameter int unsigned       DATA_W     = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 24'h010000,
    parameter int unsigned       WIN_BYTES  = 32'h8000,
    parameter int unsigned       PAGE_BYTES = 32'h2000,
    parameter logic [ADDR_W-1:0] CACHE_BASE = 24'h002000,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 24'h00FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_req,
    input  logic [ADDR_W-1:0] if_addr,
    output logic              if_mem_req,
    output logic [ADDR_W-1:0] if_mem_addr,
    input  logic              d_req,
    input  logic              d_we,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [DATA_W-1:0] d_wdata,
    output logic              d_mem_req,
    output logic [ADDR_W-1:0] d_mem_addr,
    output logic              trap,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              fault_fetch
);
    localparam int unsigned NPAGES = WIN_BYTES / PAGE_BYTES;
    localparam int unsigned TAG_W  = (NPAGES > 1) ? $clog2(NPAGES) : 1;

    logic             ctrl_wr;
    logic             d_port_req;
    logic [TAG_W-1:0] cur_tag;
    logic             cur_valid;
    logic             d_miss;
    logic             i_miss;
    fault_src_e       src;

    // Control write decode; such a write is taken away from memory.
    always_comb begin
        ctrl_wr    = d_req && d_we && (d_addr == CTRL_ADDR);
        d_port_req = d_req && !ctrl_wr;
    end

    vrom_xlate #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
        .PAGE_BYTES(PAGE_BYTES), .CACHE_BASE(CACHE_BASE)
    ) u_fetch_xlate (
        .clk(clk), .rst_n(rst_n),
        .req(if_req), .we(1'b0), .addr(if_addr),
        .cur_tag(cur_tag), .cur_valid(cur_valid),
        .mem_req(if_mem_req), .mem_addr(if_mem_addr), .miss(i_miss)
    );

    vrom_xlate #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES),
        .PAGE_BYTES(PAGE_BYTES), .CACHE_BASE(CACHE_BASE)
    ) u_data_xlate (
        .clk(clk), .rst_n(rst_n),
        .req(d_port_req), .we(d_we), .addr(d_addr),
        .cur_tag(cur_tag), .cur_valid(cur_valid),
        .mem_req(d_mem_req), .mem_addr(d_mem_addr), .miss(d_miss)
    );

    vrom_trap_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_trap_ctl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .wdata(d_wdata),
        .d_miss(d_miss), .d_addr(d_addr),
        .i_miss(i_miss), .i_addr(if_addr),
        .tag(cur_tag), .valid(cur_valid),
        .trap(trap), .fault_addr(fault_addr), .fault_src(src)
    );

    assign fault_fetch = (src == SRC_FETCH);

    // R5
    ctrl_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |-> !d_mem_req);

    // R2
    outside_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && ({1'b0, if_addr} < {1'b0, WIN_BASE})) |-> (if_mem_req && if_mem_addr == if_addr));
endmodule

// File: tb/vrom_window_bench.sv
// Directed bench for the virtual ROM window translator.
module vrom_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_req = 1'b0;
    logic [23:0] if_addr = '0;
    logic        if_mem_req;
    logic [23:0] if_mem_addr;
    logic        d_req = 1'b0;
    logic        d_we = 1'b0;
    logic [23:0] d_addr = '0;
    logic [31:0] d_wdata = '0;
    logic        d_mem_req;
    logic [23:0] d_mem_addr;
    logic        trap;
    logic [23:0] fault_addr;
    logic        fault_fetch;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    localparam logic [23:0] CTRL = 24'h00FFF0;

    always #4 clk = ~clk;

    vrom_window u_vrom_window (
        .clk(clk), .rst_n(rst_n),
        .if_req(if_req), .if_addr(if_addr),
        .if_mem_req(if_mem_req), .if_mem_addr(if_mem_addr),
        .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
        .d_mem_req(d_mem_req), .d_mem_addr(d_mem_addr),
        .trap(trap), .fault_addr(fault_addr), .fault_fetch(fault_fetch)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive all inputs at a falling edge, then let combinational paths settle.
    task automatic apply(bit ir, logic [23:0] ia, bit dr, bit dw, logic [23:0] da, logic [31:0] wd);
        @(negedge clk);
        if_req = ir; if_addr = ia; d_req = dr; d_we = dw; d_addr = da; d_wdata = wd;
        #1;
    endtask

    // Pass one rising edge and sample just after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ctrl_write(logic [31:0] wd);
        apply(0, '0, 1, 1, CTRL, wd);
        step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 trap after reset", 32'(trap), 32'd0);
        chk("R1 fault addr after reset", 32'(fault_addr), 32'd0);
    endtask

    task automatic t_passthrough();
        apply(1, 24'h00FFFF, 1, 0, 24'h001234, '0);
        chk("R2 fetch below window req", 32'(if_mem_req), 32'd1);
        chk("R2 fetch below window addr", 32'(if_mem_addr), 32'h00FFFF);
        chk("R2 data low addr", 32'(d_mem_addr), 32'h001234);
        step();
        apply(1, 24'h018000, 1, 0, 24'h020000, '0);
        chk("R2 fetch at window end req", 32'(if_mem_req), 32'd1);
        chk("R2 fetch at window end addr", 32'(if_mem_addr), 32'h018000);
        chk("R2 data above window addr", 32'(d_mem_addr), 32'h020000);
        step();
        chk("R2 no trap outside", 32'(trap), 32'd0);
    endtask

    task automatic t_first_miss();
        apply(0, '0, 1, 0, 24'h010004, '0);
        chk("R1 first window read blocked", 32'(d_mem_req), 32'd0);
        step();
        chk("R3 trap raised", 32'(trap), 32'd1);
        chk("R4 fault addr data", 32'(fault_addr), 32'h010004);
        chk("R4 fault source data", 32'(fault_fetch), 32'd0);
        apply(1, 24'h014000, 0, 0, '0, '0);
        chk("R7 fetch miss blocked", 32'(if_mem_req), 32'd0);
        step();
        chk("R4 trap held", 32'(trap), 32'd1);
        chk("R4 fault addr kept", 32'(fault_addr), 32'h010004);
        chk("R4 fault source kept", 32'(fault_fetch), 32'd0);
    endtask

    task automatic t_reserved();
        apply(0, '0, 1, 1, CTRL, 32'h8000_0100);
        chk("R12 reserved write not forwarded", 32'(d_mem_req), 32'd0);
        step();
        chk("R12 reserved write keeps trap", 32'(trap), 32'd1);
        apply(0, '0, 1, 0, 24'h010004, '0);
        chk("R12 page still not resident", 32'(d_mem_req), 32'd0);
    endtask

    task automatic t_load_page0();
        apply(0, '0, 1, 1, CTRL, 32'h8000_0000);
        chk("R5 control write not forwarded", 32'(d_mem_req), 32'd0);
        step();
        chk("R5 control write clears trap", 32'(trap), 32'd0);
        apply(0, '0, 1, 0, 24'h010004, '0);
        chk("R6 hit forwarded", 32'(d_mem_req), 32'd1);
        chk("R6 hit addr", 32'(d_mem_addr), 32'h002004);
        apply(0, '0, 1, 0, 24'h011FFE, '0);
        chk("R6 page end addr", 32'(d_mem_addr), 32'h003FFE);
        step();
        chk("R6 no trap on hit", 32'(trap), 32'd0);
    endtask

    task automatic t_fetch();
        apply(1, 24'h011000, 0, 0, '0, '0);
        chk("R7 fetch hit addr", 32'(if_mem_addr), 32'h003000);
        apply(1, 24'h012000, 0, 0, '0, '0);
        chk("R7 fetch miss blocked", 32'(if_mem_req), 32'd0);
        step();
        chk("R7 fetch trap", 32'(trap), 32'd1);
        chk("R4 fault addr fetch", 32'(fault_addr), 32'h012000);
        chk("R4 fault source fetch", 32'(fault_fetch), 32'd1);
        ctrl_write(32'h8000_0001);
        chk("R5 trap cleared", 32'(trap), 32'd0);
        apply(1, 24'h012000, 0, 0, '0, '0);
        chk("R7 fetch page1 start", 32'(if_mem_addr), 32'h002000);
        apply(1, 24'h013FFF, 0, 0, '0, '0);
        chk("R7 fetch page1 last", 32'(if_mem_addr), 32'h003FFF);
        chk("R7 fetch page1 req", 32'(if_mem_req), 32'd1);
        apply(0, '0, 1, 0, 24'h010004, '0);
        chk("R11 old page misses", 32'(d_mem_req), 32'd0);
        step();
        chk("R11 old page trap", 32'(trap), 32'd1);
        chk("R11 fault addr", 32'(fault_addr), 32'h010004);
    endtask

    task automatic t_write();
        ctrl_write(32'h8000_0003);
        chk("R5 trap cleared tag3", 32'(trap), 32'd0);
        apply(0, '0, 1, 1, 24'h010010, 32'h55);
        chk("R8 window write forwarded", 32'(d_mem_req), 32'd1);
        chk("R8 window write addr", 32'(d_mem_addr), 32'h010010);
        step();
        chk("R8 no trap on write", 32'(trap), 32'd0);
        apply(0, '0, 1, 0, 24'h017FFE, '0);
        chk("R6 last page addr", 32'(d_mem_addr), 32'h003FFE);
    endtask

    task automatic t_dual();
        apply(1, 24'h012040, 1, 0, 24'h010020, '0);
        chk("R9 fetch blocked", 32'(if_mem_req), 32'd0);
        chk("R9 data blocked", 32'(d_mem_req), 32'd0);
        step();
        chk("R9 trap", 32'(trap), 32'd1);
        chk("R9 data addr recorded", 32'(fault_addr), 32'h010020);
        chk("R9 data source", 32'(fault_fetch), 32'd0);
        ctrl_write(32'h8000_0003);
        chk("R5 trap cleared dual", 32'(trap), 32'd0);
    endtask

    task automatic t_invalidate();
        ctrl_write(32'h0000_0003);
        chk("R10 invalidate clears trap", 32'(trap), 32'd0);
        apply(0, '0, 1, 0, 24'h017FFE, '0);
        chk("R10 invalid page blocked", 32'(d_mem_req), 32'd0);
        step();
        chk("R10 invalid page trap", 32'(trap), 32'd1);
    endtask

    initial begin
        t_reset();
        t_passthrough();
        t_first_miss();
        t_reserved();
        t_load_page0();
        t_fetch();
        t_write();
        t_dual();
        t_invalidate();
        apply(0, '0, 0, 0, '0, '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule